// File: doc/BRIEF.md
# Chip-Select Decoder with Wait States

This block sits between a processor's external bus port and the devices wired to it. When an access begins, it checks the 24-bit address against three kinds of region: a RAM window at the bottom of the space, a ROM window near the top, and a row of small peripheral windows placed in the data space just above the RAM. It then drives the matching active-low select. It also holds the requester off for a number of wait cycles set by software, and it passes the read and write strobes on to the selected device.

An access is accepted on a clock edge where `acc_valid` is high and no access is in flight. At that edge the block latches the decoded region, the direction and the current wait setting. It keeps the select low while it counts down the latched number of wait cycles. It then raises `acc_ready` for one cycle and releases everything on the following edge. An address outside every region still completes on the same schedule, but it selects nothing and reads back all ones. At reset the wait setting is the slowest value, so a boot image in slow ROM can be fetched before software tunes the timing.

Top module: `csel_wait_ctrl`

## Requirements
- R1: After reset, every select, `rd_n` and `wr_n` are high, `acc_ready` is low, and the wait setting is 3.
- R2: Addresses 0x000000 through 0x007FFF drive `ram_cs_n` low and no other select.
- R3: Addresses from 0x0FC0000 (written 0xFC0000) up to 0xFFFFFF drive `rom_cs_n` low, and 0xFBFFFF does not. The 512 kB window is clipped at the top of the 24-bit space.
- R4: There are NPER peripheral windows of PER_BYTES each, starting at PER_BASE. The defaults are 4 windows of 256 bytes from 0x008000. An address in window k drives `per_cs_n[k]` low, and bit 0 is the lowest window.
- R5: At most one select is low in any cycle, and all selects are high whenever no access is in flight.
- R6: For an access accepted on edge E with wait setting N, `acc_ready` stays low for the N cycles after E. It is high in cycle N+1 only, and the select is held through that cycle and released on the next edge.
- R7: A write of 1, 2 or 3 through `cfg_we`/`cfg_wdata` sets the wait setting from the next edge on. A write of 0 is ignored and keeps the previous setting.
- R8: The wait setting is sampled when an access is accepted. A write during the access does not change that access's length.
- R9: An address in no region drives no select and no strobe. It completes after the programmed number of wait cycles, with `acc_rdata` = 0xFFFF.
- R10: `rd_n` (or `wr_n`) is low for the whole time the select is low when a read (or write) hits a region. If both `acc_rd` and `acc_wr` are high, the read wins and `wr_n` stays high.
- R11: For a mapped read, `acc_rdata` equals `mem_rdata` in the ready cycle.
- R12: `acc_valid` and address changes during an access in flight are ignored. The latched select does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write enable for the wait setting |
| cfg_wdata | input | 2 | New wait setting (1..3) |
| acc_valid | input | 1 | Requester starts an access |
| acc_addr | input | 24 | Access address |
| acc_rd | input | 1 | Access is a read |
| acc_wr | input | 1 | Access is a write |
| mem_rdata | input | 16 | Read data from the selected device |
| acc_rdata | output | 16 | Read data returned to the requester |
| acc_ready | output | 1 | One-cycle completion pulse |
| ram_cs_n | output | 1 | RAM select, active low |
| rom_cs_n | output | 1 | ROM select, active low |
| per_cs_n | output | 4 | Peripheral window selects, active low |
| rd_n | output | 1 | Gated read strobe, active low |
| wr_n | output | 1 | Gated write strobe, active low |

## Verification
The bench builds the block with its default map: the RAM at 32 kB, the ROM base at 0xFC0000, and four 256-byte peripheral windows from 0x008000, with a two-bit wait setting. With these windows small and placed next to one another, a handful of addresses covers every edge: the last RAM byte, the first byte of window 0, the step from window 0 to window 1, the end of window 3 and the first unmapped byte above it. The two-bit setting means all three legal lengths and the rejected zero can each be tried, including a change made during an access in flight.

// File: rtl/csw_pkg.sv
package csw_pkg;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_RAM  = 2'd1,
        RGN_ROM  = 2'd2,
        RGN_PER  = 2'd3
    } rgn_e;

endpackage

// File: rtl/csw_addr_decode.sv
module csw_addr_decode #(
    parameter int          AW        = 24,
    parameter logic [31:0] RAM_BASE  = 32'h0000_0000,
    parameter logic [31:0] RAM_BYTES = 32'h0000_8000,
    parameter logic [31:0] ROM_BASE  = 32'h00FC_0000,
    parameter logic [31:0] ROM_BYTES = 32'h0008_0000,
    parameter logic [31:0] PER_BASE  = 32'h0000_8000,
    parameter logic [31:0] PER_BYTES = 32'h0000_0100,
    parameter int          NPER      = 4
) (
    input  logic [AW-1:0]   addr,
    output csw_pkg::rgn_e   rgn,
    output logic [NPER-1:0] per_hit
);
    import csw_pkg::*;

    // all compares are done one bit wider than 32 so a window that runs
    // past the top of the address space simply clips there
    localparam logic [32:0] RAM_LO = 33'(RAM_BASE);
    localparam logic [32:0] RAM_HI = 33'(RAM_BASE) + 33'(RAM_BYTES);
    localparam logic [32:0] ROM_LO = 33'(ROM_BASE);
    localparam logic [32:0] ROM_HI = 33'(ROM_BASE) + 33'(ROM_BYTES);

    logic [32:0] a_ext;
    logic        ram_hit;
    logic        rom_hit;

    assign a_ext   = 33'(addr);
    assign ram_hit = (a_ext >= RAM_LO) && (a_ext < RAM_HI);
    assign rom_hit = (a_ext >= ROM_LO) && (a_ext < ROM_HI);

    for (genvar g = 0; g < NPER; g++) begin : g_win
        localparam logic [32:0] WLO = 33'(PER_BASE) + 33'(g) * 33'(PER_BYTES);
        localparam logic [32:0] WHI = WLO + 33'(PER_BYTES);
        assign per_hit[g] = (a_ext >= WLO) && (a_ext < WHI);
    end

    // fixed priority keeps the result unique even if windows overlap
    always_comb begin
        rgn = RGN_NONE;
        if (|per_hit) begin
            rgn = RGN_PER;
        end else if (ram_hit) begin
            rgn = RGN_RAM;
        end else if (rom_hit) begin
            rgn = RGN_ROM;
        end
    end

endmodule

// File: rtl/csw_wait_cfg.sv
module csw_wait_cfg #(
    parameter int WAIT_W   = 2,
    parameter int WAIT_MAX = 3,
    parameter int WAIT_RST = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [WAIT_W-1:0] cfg_wdata,
    output logic [WAIT_W-1:0] wait_cyc
);
    localparam logic [WAIT_W-1:0] W_MAX = WAIT_W'(WAIT_MAX);
    localparam logic [WAIT_W-1:0] W_RST = WAIT_W'(WAIT_RST);

    logic [WAIT_W-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we && (cfg_wdata != '0) && (cfg_wdata <= W_MAX)) begin
            cfg_d = cfg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= W_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign wait_cyc = cfg_q;

    // R7
    cfg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q != '0) && (cfg_q <= W_MAX));

    // R7
    cfg_zero_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata == '0) |=> $stable(cfg_q));

endmodule

// File: rtl/csw_access_seq.sv
module csw_access_seq #(
    parameter int WAIT_W = 2,
    parameter int NPER   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  csw_pkg::rgn_e     rgn_in,
    input  logic [NPER-1:0]   per_in,
    input  logic [WAIT_W-1:0] wait_cyc,
    output logic              busy,
    output logic              done,
    output csw_pkg::rgn_e     rgn_out,
    output logic [NPER-1:0]   per_out,
    output logic              rd_out,
    output logic              wr_out
);
    import csw_pkg::*;

    typedef struct packed {
        logic              active;
        logic [WAIT_W-1:0] cnt;
        rgn_e              rgn;
        logic [NPER-1:0]   per;
        logic              rd;
        logic              wr;
    } seq_t;

    localparam seq_t SEQ_IDLE = '{active: 1'b0, cnt: '0, rgn: RGN_NONE,
                                  per: '0, rd: 1'b0, wr: 1'b0};

    seq_t seq_d, seq_q;
    logic start;

    assign start = !seq_q.active && acc_valid;

    always_comb begin
        seq_d = seq_q;
        if (start) begin
            seq_d.active = 1'b1;
            seq_d.cnt    = wait_cyc;
            seq_d.rgn    = rgn_in;
            seq_d.per    = per_in;
            seq_d.rd     = acc_rd;
            seq_d.wr     = acc_wr && !acc_rd;
        end else if (seq_q.active) begin
            if (seq_q.cnt == '0) begin
                seq_d = SEQ_IDLE;
            end else begin
                seq_d.cnt = seq_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= SEQ_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy    = seq_q.active;
    assign done    = seq_q.active && (seq_q.cnt == '0);
    assign rgn_out = seq_q.rgn;
    assign per_out = seq_q.per;
    assign rd_out  = seq_q.rd;
    assign wr_out  = seq_q.wr;

    // R6
    start_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !done));

    // R12
    hold_rgn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(rgn_out) && $stable(per_out)));

endmodule

// File: rtl/csel_wait_ctrl.sv
module csel_wait_ctrl #(
    parameter int          AW        = 24,
    parameter int          DW        = 16,
    parameter int          NPER      = 4,
    parameter int          WAIT_W    = 2,
    parameter int          WAIT_MAX  = 3,
    parameter int          WAIT_RST  = 3,
    parameter logic [31:0] RAM_BASE  = 32'h0000_0000,
    parameter logic [31:0] RAM_BYTES = 32'h0000_8000,
    parameter logic [31:0] ROM_BASE  = 32'h00FC_0000,
    parameter logic [31:0] ROM_BYTES = 32'h0008_0000,
    parameter logic [31:0] PER_BASE  = 32'h0000_8000,
    parameter logic [31:0] PER_BYTES = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [WAIT_W-1:0] cfg_wdata,
    input  logic              acc_valid,
    input  logic [AW-1:0]     acc_addr,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic [DW-1:0]     mem_rdata,
    output logic [DW-1:0]     acc_rdata,
    output logic              acc_ready,
    output logic              ram_cs_n,
    output logic              rom_cs_n,
    output logic [NPER-1:0]   per_cs_n,
    output logic              rd_n,
    output logic              wr_n
);
    import csw_pkg::*;

    rgn_e              dec_rgn;
    logic [NPER-1:0]   dec_per;
    logic [WAIT_W-1:0] wait_cyc;
    logic              busy;
    logic              done;
    rgn_e              cur_rgn;
    logic [NPER-1:0]   cur_per;
    logic              cur_rd;
    logic              cur_wr;
    logic              mapped;

    csw_addr_decode #(
        .AW(AW), .RAM_BASE(RAM_BASE), .RAM_BYTES(RAM_BYTES),
        .ROM_BASE(ROM_BASE), .ROM_BYTES(ROM_BYTES),
        .PER_BASE(PER_BASE), .PER_BYTES(PER_BYTES), .NPER(NPER)
    ) u_dec (
        .addr    (acc_addr),
        .rgn     (dec_rgn),
        .per_hit (dec_per)
    );

    csw_wait_cfg #(
        .WAIT_W(WAIT_W), .WAIT_MAX(WAIT_MAX), .WAIT_RST(WAIT_RST)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .wait_cyc  (wait_cyc)
    );

    csw_access_seq #(
        .WAIT_W(WAIT_W), .NPER(NPER)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_rd    (acc_rd),
        .acc_wr    (acc_wr),
        .rgn_in    (dec_rgn),
        .per_in    (dec_per),
        .wait_cyc  (wait_cyc),
        .busy      (busy),
        .done      (done),
        .rgn_out   (cur_rgn),
        .per_out   (cur_per),
        .rd_out    (cur_rd),
        .wr_out    (cur_wr)
    );

    assign mapped    = busy && (cur_rgn != RGN_NONE);
    assign ram_cs_n  = !(busy && cur_rgn == RGN_RAM);
    assign rom_cs_n  = !(busy && cur_rgn == RGN_ROM);
    assign per_cs_n  = ~((busy && cur_rgn == RGN_PER) ? cur_per : '0);
    assign rd_n      = !(mapped && cur_rd);
    assign wr_n      = !(mapped && cur_wr);
    assign acc_ready = done;
    assign acc_rdata = mapped ? mem_rdata : '1;

    // R5
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~ram_cs_n, ~rom_cs_n, ~per_cs_n}));

    // R6
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ready |=> !acc_ready);

    // R5
    release_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ready |=> (ram_cs_n && rom_cs_n && (&per_cs_n) && rd_n && wr_n));

    // R10
    strobe_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> (!ram_cs_n || !rom_cs_n || !(&per_cs_n)));

    // R10
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

endmodule

// File: tb/csel_wait_ctrl_tb.sv
module csel_wait_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [23:0] acc_addr = '0;
    logic        acc_rd = 1'b0;
    logic        acc_wr = 1'b0;
    logic [15:0] mem_rdata = 16'h5A3C;
    logic [15:0] acc_rdata;
    logic        acc_ready;
    logic        ram_cs_n;
    logic        rom_cs_n;
    logic [3:0]  per_cs_n;
    logic        rd_n;
    logic        wr_n;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    csel_wait_ctrl #(
        .AW(24), .DW(16), .NPER(4), .WAIT_W(2), .WAIT_MAX(3), .WAIT_RST(3),
        .RAM_BASE(32'h0), .RAM_BYTES(32'h8000),
        .ROM_BASE(32'hFC0000), .ROM_BYTES(32'h80000),
        .PER_BASE(32'h8000), .PER_BYTES(32'h100)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_rd(acc_rd),
        .acc_wr(acc_wr), .mem_rdata(mem_rdata), .acc_rdata(acc_rdata),
        .acc_ready(acc_ready), .ram_cs_n(ram_cs_n), .rom_cs_n(rom_cs_n),
        .per_cs_n(per_cs_n), .rd_n(rd_n), .wr_n(wr_n)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic set_wait(input logic [1:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic chk_idle(input string tag);
        chk({ram_cs_n, rom_cs_n, per_cs_n, rd_n, wr_n, acc_ready} == 9'b111111110,
            tag, {ram_cs_n, rom_cs_n, per_cs_n, rd_n, wr_n, acc_ready}, 9'b111111110);
    endtask

    // exp_sel bits: [5] RAM, [4] ROM, [3:0] peripheral windows (active high)
    task automatic do_acc(input logic [23:0] a, input logic r, input logic w,
                          input int exp_wait, input logic [5:0] exp_sel,
                          input logic [1:0] mid_cfg, input bit hold,
                          input logic [23:0] a2, input string tag);
        int   waits = 0;
        bit   fin   = 0;
        bit   mapd;
        logic [5:0] sel_act;
        mapd = |exp_sel;
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_rd = r; acc_wr = w;
        @(negedge clk);
        if (hold) begin
            acc_addr = a2; acc_rd = 1'b1; acc_wr = 1'b0;
        end else begin
            acc_valid = 1'b0; acc_rd = 1'b0; acc_wr = 1'b0;
        end
        for (int k = 0; k < 8 && !fin; k++) begin
            if (k > 0) begin
                @(negedge clk);
                cfg_we = 1'b0;
            end
            sel_act = {~ram_cs_n, ~rom_cs_n, ~per_cs_n};
            chk(sel_act == exp_sel, {tag, " R5 select pattern"},
                32'(sel_act), 32'(exp_sel));
            chk(rd_n == !(mapd && r), {tag, " R10 rd_n"}, 32'(rd_n), 32'(!(mapd && r)));
            chk(wr_n == !(mapd && w && !r), {tag, " R10 wr_n"},
                32'(wr_n), 32'(!(mapd && w && !r)));
            if (acc_ready) begin
                fin = 1;
                acc_valid = 1'b0; acc_rd = 1'b0; acc_wr = 1'b0;
                if (r) begin
                    chk(acc_rdata == (mapd ? mem_rdata : 16'hFFFF),
                        {tag, mapd ? " R11 read data" : " R9 all-ones data"},
                        32'(acc_rdata), 32'(mapd ? mem_rdata : 16'hFFFF));
                end
            end else begin
                waits++;
            end
            if (k == 0 && mid_cfg != 2'd0) begin
                cfg_we = 1'b1; cfg_wdata = mid_cfg;
            end
        end
        cfg_we = 1'b0;
        chk(fin == 1'b1 && waits == exp_wait, {tag, " R6 wait cycles"},
            32'(waits), 32'(exp_wait));
        @(negedge clk);
        chk_idle({tag, " R5 released after ready"});
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk_idle("R1 idle in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 idle after reset");
        // reset wait setting is 3
        do_acc(24'h000010, 1, 0, 3, 6'b100000, 0, 0, 0, "R1 reset wait=3 R2");
    endtask

    task automatic t_ram;
        set_wait(2'd1);
        do_acc(24'h000000, 1, 0, 1, 6'b100000, 0, 0, 0, "R2 ram low");
        do_acc(24'h007FFF, 0, 1, 1, 6'b100000, 0, 0, 0, "R2 ram top write");
    endtask

    task automatic t_cfg;
        set_wait(2'd2);
        do_acc(24'h001234, 1, 0, 2, 6'b100000, 0, 0, 0, "R7 wait=2");
        set_wait(2'd0);
        do_acc(24'h001234, 1, 0, 2, 6'b100000, 0, 0, 0, "R7 zero ignored");
        set_wait(2'd3);
        do_acc(24'h001234, 0, 1, 3, 6'b100000, 0, 0, 0, "R7 wait=3");
    endtask

    task automatic t_rom;
        set_wait(2'd1);
        do_acc(24'hFC0000, 1, 0, 1, 6'b010000, 0, 0, 0, "R3 rom base");
        do_acc(24'hFFFFFF, 1, 0, 1, 6'b010000, 0, 0, 0, "R3 rom top");
        do_acc(24'hFBFFFF, 1, 0, 1, 6'b000000, 0, 0, 0, "R3 R9 below rom");
    endtask

    task automatic t_per;
        set_wait(2'd1);
        do_acc(24'h008000, 1, 0, 1, 6'b000001, 0, 0, 0, "R4 win0 first");
        do_acc(24'h0080FF, 0, 1, 1, 6'b000001, 0, 0, 0, "R4 win0 last");
        do_acc(24'h008100, 1, 0, 1, 6'b000010, 0, 0, 0, "R4 win1 first");
        do_acc(24'h008234, 1, 0, 1, 6'b000100, 0, 0, 0, "R4 win2");
        do_acc(24'h0083FF, 1, 0, 1, 6'b001000, 0, 0, 0, "R4 win3 last");
        do_acc(24'h008400, 1, 0, 1, 6'b000000, 0, 0, 0, "R4 R9 above windows");
    endtask

    task automatic t_unmapped;
        set_wait(2'd2);
        do_acc(24'h500000, 1, 0, 2, 6'b000000, 0, 0, 0, "R9 unmapped read");
        do_acc(24'h400002, 0, 1, 2, 6'b000000, 0, 0, 0, "R9 unmapped write");
    endtask

    task automatic t_both;
        set_wait(2'd1);
        do_acc(24'h000100, 1, 1, 1, 6'b100000, 0, 0, 0, "R10 rd wins");
    endtask

    task automatic t_cfg_mid;
        set_wait(2'd3);
        do_acc(24'h000200, 1, 0, 3, 6'b100000, 2'd1, 0, 0, "R8 mid write");
        do_acc(24'h000200, 1, 0, 1, 6'b100000, 0, 0, 0, "R8 new setting next");
    endtask

    task automatic t_busy;
        set_wait(2'd3);
        do_acc(24'h000300, 1, 0, 3, 6'b100000, 0, 1, 24'hFC0010, "R12 busy ignore");
    endtask

    initial begin
        t_reset();
        t_ram();
        t_cfg();
        t_rom();
        t_per();
        t_unmapped();
        t_both();
        t_cfg_mid();
        t_busy();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule